// File: doc/BRIEF.md
# Symbolic Load/Store Address and Set Index Generator

This block gives an early-stage data cache its lookup address straight from the encoding fields of a load or store. It does not wait for the register file or the address adder. The symbolic address is built from three fields. The displacement fills the low bits. The base register number sits above the displacement. Above the register number goes a call-depth color, but only when the base register is the stack pointer or the frame pointer. The color keeps the stack frames of a caller and its callees apart. References through any other register get a zero color field, so global data stays shared across procedures.

The color is a small counter. Each procedure-call pulse moves it up and each return pulse moves it down. The set index is not taken plainly from the address. It is the XOR of the bits just above the line offset with the bits that hold the register number and the low color bits. This spreads references whose upper displacement bits are mostly zero. The tag and the line offset are cut from the same symbolic address. All outputs are registered and appear one cycle after the request strobe.

Top module: `symaddr_gen`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, out_valid is 0 and out_sym, out_set, out_tag and out_off are all zero. The call-depth color starts at 0.
- R2: One cycle after in_valid, out_sym[15:0] equals the displacement and out_sym[20:16] equals the base register number of that request.
- R3: When the base register is 29 (stack pointer) or 30 (frame pointer), out_sym[22:21] holds the color. For any other register, out_sym[22:21] is 0.
- R4: A call pulse alone adds one to the color and a return pulse alone subtracts one. Several calls in a row keep raising it before any return.
- R5: The 2-bit color wraps modulo 4. A call at 3 gives 0, and a return at 0 gives 3. It does not saturate.
- R6: A call pulse and a return pulse in the same cycle cancel, and the color is left unchanged.
- R7: A request that arrives in the same cycle as a call or return pulse uses the color from before that cycle's update.
- R8: out_set equals out_sym[11:6] XOR out_sym[21:16].
- R9: out_off equals out_sym[5:0], and out_tag equals out_sym[22:6], which includes the color field.
- R10: out_valid equals in_valid delayed by one cycle. In a cycle without in_valid, out_sym, out_set, out_tag and out_off keep their previous values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request strobe for one memory instruction |
| in_base_reg | input | 5 | Base register number from the encoding |
| in_disp | input | 16 | Displacement field from the encoding |
| call_pulse | input | 1 | Procedure call event |
| ret_pulse | input | 1 | Procedure return event |
| out_valid | output | 1 | Registered result is valid |
| out_sym | output | 23 | Symbolic address: color, register number, displacement |
| out_set | output | 6 | Randomized set index |
| out_tag | output | 17 | Symbolic address above the line offset |
| out_off | output | 6 | Line offset |

## Verification
On every cycle, the assertions check that the color steps, wraps and cancels correctly. They also check that the displacement and register fields reach the registered address, that a stack reference carries the pre-update color while any other reference carries none, that the set index follows the XOR rule, and that outputs hold while no request arrives. The assertions can see the internal color, but the bench cannot. The bench therefore has to reveal the call depth through stack-pointer and frame-pointer requests placed after call and return sequences. Only those scenarios show that deep nesting, wrap in both directions, and a request that coincides with a call or return produce the expected address. The tag and offset slicing are also confirmed only through those scenarios.

// File: rtl/symaddr_pkg.sv
package symaddr_pkg;

  typedef enum logic [1:0] {
    CLR_HOLD = 2'd0,
    CLR_UP   = 2'd1,
    CLR_DOWN = 2'd2
  } clr_step_e;

  // Call and return in the same cycle cancel each other.
  function automatic clr_step_e decode_step(input logic call_ev, input logic ret_ev);
    if (call_ev && !ret_ev)      return CLR_UP;
    else if (ret_ev && !call_ev) return CLR_DOWN;
    else                         return CLR_HOLD;
  endfunction

endpackage

// File: rtl/symaddr_color.sv
module symaddr_color #(
  parameter int COLOR_W = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        call_ev,
  input  logic                        ret_ev,
  output logic [COLOR_W-1:0]          color_q,
  output symaddr_pkg::clr_step_e      step_o
);
  import symaddr_pkg::*;

  function automatic logic [COLOR_W-1:0] next_color(input logic [COLOR_W-1:0] cur,
                                                     input clr_step_e st);
    case (st)
      CLR_UP:   return cur + COLOR_W'(1);
      CLR_DOWN: return cur - COLOR_W'(1);
      default:  return cur;
    endcase
  endfunction

  assign step_o = decode_step(call_ev, ret_ev);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) color_q <= '0;
    else        color_q <= next_color(color_q, step_o);
  end
endmodule

// File: rtl/symaddr_form.sv
module symaddr_form #(
  parameter int DISP_W  = 16,
  parameter int REG_W   = 5,
  parameter int COLOR_W = 2,
  parameter int SP_REG  = 29,
  parameter int FP_REG  = 30,
  localparam int SYM_W  = DISP_W + REG_W + COLOR_W
) (
  input  logic [REG_W-1:0]   base_reg,
  input  logic [DISP_W-1:0]  disp,
  input  logic [COLOR_W-1:0] color,
  output logic               stack_ref,
  output logic [SYM_W-1:0]   sym
);
  function automatic logic is_stack(input logic [REG_W-1:0] r);
    return (r == REG_W'(SP_REG)) || (r == REG_W'(FP_REG));
  endfunction

  function automatic logic [SYM_W-1:0] build(input logic [REG_W-1:0] r,
                                             input logic [DISP_W-1:0] d,
                                             input logic [COLOR_W-1:0] c,
                                             input logic stk);
    logic [COLOR_W-1:0] cf;
    cf = stk ? c : '0;
    return {cf, r, d};
  endfunction

  assign stack_ref = is_stack(base_reg);
  assign sym       = build(base_reg, disp, color, stack_ref);
endmodule

// File: rtl/symaddr_hash.sv
module symaddr_hash #(
  parameter int SYM_W   = 23,
  parameter int OFF_W   = 6,
  parameter int IDX_W   = 6,
  parameter int MIX_LSB = 16,
  localparam int TAG_W  = SYM_W - OFF_W
) (
  input  logic [SYM_W-1:0] sym,
  output logic [IDX_W-1:0] set_idx,
  output logic [TAG_W-1:0] tag,
  output logic [OFF_W-1:0] off
);
  for (genvar i = 0; i < IDX_W; i++) begin : g_mix
    assign set_idx[i] = sym[OFF_W + i] ^ sym[MIX_LSB + i];
  end

  assign tag = sym[SYM_W-1:OFF_W];
  assign off = sym[OFF_W-1:0];
endmodule

// File: rtl/symaddr_gen.sv
module symaddr_gen #(
  parameter int DISP_W  = 16,
  parameter int REG_W   = 5,
  parameter int COLOR_W = 2,
  parameter int IDX_W   = 6,
  parameter int OFF_W   = 6,
  parameter int SP_REG  = 29,
  parameter int FP_REG  = 30,
  localparam int SYM_W  = DISP_W + REG_W + COLOR_W,
  localparam int TAG_W  = SYM_W - OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [REG_W-1:0]  in_base_reg,
  input  logic [DISP_W-1:0] in_disp,
  input  logic              call_pulse,
  input  logic              ret_pulse,
  output logic              out_valid,
  output logic [SYM_W-1:0]  out_sym,
  output logic [IDX_W-1:0]  out_set,
  output logic [TAG_W-1:0]  out_tag,
  output logic [OFF_W-1:0]  out_off
);
  logic [COLOR_W-1:0]    color_q;
  symaddr_pkg::clr_step_e clr_step;
  logic                  stack_ref;
  logic [SYM_W-1:0]      sym_c;
  logic [IDX_W-1:0]      set_c;
  logic [TAG_W-1:0]      tag_c;
  logic [OFF_W-1:0]      off_c;

  symaddr_color #(.COLOR_W(COLOR_W)) u_color (
    .clk(clk), .rst_n(rst_n), .call_ev(call_pulse), .ret_ev(ret_pulse),
    .color_q(color_q), .step_o(clr_step)
  );

  symaddr_form #(
    .DISP_W(DISP_W), .REG_W(REG_W), .COLOR_W(COLOR_W),
    .SP_REG(SP_REG), .FP_REG(FP_REG)
  ) u_form (
    .base_reg(in_base_reg), .disp(in_disp), .color(color_q),
    .stack_ref(stack_ref), .sym(sym_c)
  );

  symaddr_hash #(
    .SYM_W(SYM_W), .OFF_W(OFF_W), .IDX_W(IDX_W), .MIX_LSB(DISP_W)
  ) u_hash (
    .sym(sym_c), .set_idx(set_c), .tag(tag_c), .off(off_c)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_sym   <= '0;
      out_set   <= '0;
      out_tag   <= '0;
      out_off   <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_sym <= sym_c;
        out_set <= set_c;
        out_tag <= tag_c;
        out_off <= off_c;
      end
    end
  end
endmodule

// File: rtl/symaddr_gen_chk.sv
module symaddr_gen_chk #(
  parameter int DISP_W  = 16,
  parameter int REG_W   = 5,
  parameter int COLOR_W = 2,
  parameter int IDX_W   = 6,
  parameter int OFF_W   = 6,
  parameter int SP_REG  = 29,
  parameter int FP_REG  = 30,
  localparam int SYM_W  = DISP_W + REG_W + COLOR_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [REG_W-1:0]  in_base_reg,
  input logic [DISP_W-1:0] in_disp,
  input logic              call_pulse,
  input logic              ret_pulse,
  input logic              out_valid,
  input logic [SYM_W-1:0]  out_sym,
  input logic [IDX_W-1:0]  out_set,
  input logic [COLOR_W-1:0] color_q,
  input logic              stack_ref
);
  localparam int CLSB = DISP_W + REG_W;

  a_r4_call_up: assert property (@(posedge clk) disable iff (!rst_n)
    (call_pulse && !ret_pulse) |=> color_q == COLOR_W'($past(color_q) + 1'b1));

  a_r5_ret_down: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_pulse && !call_pulse) |=> color_q == COLOR_W'($past(color_q) - 1'b1));

  a_r6_cancel: assert property (@(posedge clk) disable iff (!rst_n)
    (call_pulse == ret_pulse) |=> $stable(color_q));

  a_r2_fields: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (out_sym[DISP_W-1:0] == $past(in_disp)) &&
                 (out_sym[CLSB-1:DISP_W] == $past(in_base_reg)));

  a_r7_old_color: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && stack_ref) |=> out_sym[SYM_W-1:CLSB] == $past(color_q));

  a_r3_no_color: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_base_reg != REG_W'(SP_REG) && in_base_reg != REG_W'(FP_REG))
      |=> out_sym[SYM_W-1:CLSB] == '0);

  a_r8_index: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_set == (out_sym[OFF_W +: IDX_W] ^ out_sym[DISP_W +: IDX_W]));

  a_r10_valid: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid && $stable(out_sym) && $stable(out_set));
endmodule

bind symaddr_gen symaddr_gen_chk #(
  .DISP_W(DISP_W), .REG_W(REG_W), .COLOR_W(COLOR_W), .IDX_W(IDX_W),
  .OFF_W(OFF_W), .SP_REG(SP_REG), .FP_REG(FP_REG)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_base_reg(in_base_reg),
  .in_disp(in_disp), .call_pulse(call_pulse), .ret_pulse(ret_pulse),
  .out_valid(out_valid), .out_sym(out_sym), .out_set(out_set),
  .color_q(color_q), .stack_ref(stack_ref)
);

// File: tb/symaddr_gen_tb.sv
module symaddr_gen_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [4:0]  in_base_reg = '0;
  logic [15:0] in_disp = '0;
  logic        call_pulse = 1'b0;
  logic        ret_pulse = 1'b0;
  logic        out_valid;
  logic [22:0] out_sym;
  logic [5:0]  out_set;
  logic [16:0] out_tag;
  logic [5:0]  out_off;

  int total = 0;
  int bad = 0;
  logic [1:0]  mcolor = '0;
  logic [22:0] last_sym = '0;
  bit done = 0;

  always #10 clk = ~clk;

  symaddr_gen u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_base_reg(in_base_reg),
    .in_disp(in_disp), .call_pulse(call_pulse), .ret_pulse(ret_pulse),
    .out_valid(out_valid), .out_sym(out_sym), .out_set(out_set),
    .out_tag(out_tag), .out_off(out_off)
  );

  function automatic logic [22:0] exp_sym(input logic [4:0] r, input logic [15:0] d,
                                          input logic [1:0] c);
    logic [22:0] s;
    s = 23'(d) | (23'(r) << 16);
    if (r == 5'd29 || r == 5'd30) s = s | (23'(c) << 21);
    return s;
  endfunction

  function automatic logic [5:0] exp_set(input logic [22:0] s);
    return 6'((s >> 6) & 23'h3f) ^ 6'((s >> 16) & 23'h3f);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drive one cycle at negedge, check after the following posedge.
  task automatic step(input logic v, input logic [4:0] r, input logic [15:0] d,
                      input logic c, input logic rt, input string req);
    logic [22:0] es;
    in_valid = v; in_base_reg = r; in_disp = d; call_pulse = c; ret_pulse = rt;
    es = v ? exp_sym(r, d, mcolor) : last_sym;
    @(posedge clk);
    @(negedge clk);
    if (c && !rt) mcolor = mcolor + 2'd1;
    else if (rt && !c) mcolor = mcolor - 2'd1;
    chk({req, " R10 valid"}, 32'(out_valid), 32'(v));
    chk({req, " sym"}, 32'(out_sym), 32'(es));
    chk("R8 set", 32'(out_set), 32'(exp_set(es)));
    chk("R9 tag", 32'(out_tag), 32'(es >> 6));
    chk("R9 off", 32'(out_off), 32'(es & 23'h3f));
    last_sym = es;
    in_valid = 0; call_pulse = 0; ret_pulse = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed1234));
    repeat (3) @(negedge clk);
    chk("R1 valid in reset", 32'(out_valid), 0);
    chk("R1 sym in reset", 32'(out_sym), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 valid after reset", 32'(out_valid), 0);
    chk("R1 set after reset", 32'(out_set), 0);
    chk("R1 tag after reset", 32'(out_tag), 0);
    // R1: color starts at 0, seen through a stack reference
    step(1, 5'd29, 16'h1234, 0, 0, "R1 initial color");
    // R2 plain field placement, R3 no color for register 0
    step(1, 5'd0, 16'hffff, 0, 0, "R2 fields");
    // R4 nested calls
    step(0, 0, 0, 1, 0, "R4 call");
    step(0, 0, 0, 1, 0, "R4 call");
    step(1, 5'd30, 16'h0040, 0, 0, "R4 depth two FP");
    step(1, 5'd5, 16'h0840, 0, 0, "R3 other reg no color");
    // R7 request with call in same cycle uses old color (2)
    step(1, 5'd29, 16'h07c0, 1, 0, "R7 call same cycle");
    step(1, 5'd29, 16'h0000, 0, 0, "R4 depth three");
    // R5 overflow 3 -> 0
    step(1, 5'd29, 16'h0abc, 1, 0, "R7 old color before wrap");
    step(1, 5'd29, 16'h0abc, 0, 0, "R5 overflow wrap");
    // R5 underflow 0 -> 3
    step(0, 0, 0, 0, 1, "R5 return");
    step(1, 5'd30, 16'h8001, 0, 0, "R5 underflow wrap");
    // R6 cancel
    step(1, 5'd29, 16'h0101, 1, 1, "R6 cancel req");
    step(1, 5'd29, 16'h0101, 0, 0, "R6 cancel after");
    // R7 return in same cycle
    step(1, 5'd30, 16'h3003, 0, 1, "R7 ret same cycle");
    step(1, 5'd30, 16'h3003, 0, 0, "R4 after ret");
    // R10 hold with no request
    step(0, 5'd29, 16'hdead, 0, 0, "R10 hold");
    // random mix
    for (int i = 0; i < 3000; i++) begin
      logic [4:0] r;
      int sel;
      sel = $urandom_range(0, 3);
      r = (sel == 0) ? 5'd29 : (sel == 1) ? 5'd30 : 5'($urandom_range(0, 31));
      step(1'($urandom_range(0, 3) != 0), r, 16'($urandom),
           1'($urandom_range(0, 3) == 0), 1'($urandom_range(0, 3) == 0), "R2 R3 random");
    end
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule